// File: doc/BRIEF.md
# Multi-core interrupt source router

This block sits between the interrupt sources of a small processor cluster and the interrupt pins of its cores. Every core owns four local timer request lines and four mailbox-pending flags, and receives two outputs: a normal-priority interrupt and a fast interrupt. Each group of four local sources per core has an 8-bit enable register holding one normal-path enable and one fast-path enable per source. When both are set, the fast path wins, so a raised source lands on exactly one output or on neither.

A single shared upstream normal interrupt and a single shared upstream fast interrupt, coming from a peripheral controller, are steered to one core each through a routing register. The steering is not gated by the per-core enables. Software reads a per-core pending word for each output path. The outputs are recomputed combinationally from the request inputs and the configuration, so a request edge reaches a core pin with no clock delay. Configuration writes take effect at the clock edge on which the write strobe is sampled. Reads are combinational from the address.

Top module: `core_irq_router`

## Requirements
- R1: After reset the routing register and every enable register read 0. Every local source is masked, and both upstream lines are steered to core 0.
- R2: When local source k of a group has its fast enable (bit 4+k of the group's enable register) set, a raised request sets only the matching bit of that core's fast pending word. The bit is never set in the normal pending word.
- R3: When the fast enable of source k is clear and its normal enable (bit k) is set, a raised request sets the matching bit of that core's normal pending word only.
- R4: A source with both enables clear, or whose request is low, contributes to neither pending word.
- R5: Pending word layout: bits 0..3 are timer requests 0..3, bits 4..7 are mailbox flags 0..3, bit 8 is the upstream line, and all other bits read 0. The normal word of core c reads at 0x60+4c and the fast word at 0x70+4c.
- R6: The routing register at 0x0C takes the normal-interrupt target core from bits 1:0 and the fast-interrupt target core from bits 3:2. A read returns those two fields with every other bit 0.
- R7: The upstream normal line sets bit 8 of the target core's normal pending word, and the upstream fast line sets bit 8 of its target's fast pending word, whatever the enable registers hold.
- R8: The timer enable register of core c is at 0x40+4c and the mailbox enable register at 0x50+4c. A write keeps bits 7:0 of the data, and a read returns them zero-extended.
- R9: A core's normal (fast) output is high exactly when its normal (fast) pending word is nonzero. A change on a request input reaches the outputs with no clock delay.
- R10: Writes to the pending-word range 0x60..0x7F, to unmapped offsets and to non-word-aligned offsets change nothing. Reads of unmapped or non-aligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset, clears all configuration |
| timer_req | input | NUM_CORES*4 | Timer request levels, core c source k at bit 4c+k |
| mbox_pend | input | NUM_CORES*4 | Mailbox pending flags, core c mailbox k at bit 4c+k |
| up_irq | input | 1 | Shared upstream normal interrupt level |
| up_fiq | input | 1 | Shared upstream fast interrupt level |
| acc_we | input | 1 | Write strobe for the register interface |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Combinational read data for acc_addr |
| core_irq | output | NUM_CORES | Normal interrupt output per core |
| core_fiq | output | NUM_CORES | Fast interrupt output per core |

## Verification
On every cycle, the assertions check four things. An enabled source raises the output it is enabled for. Upstream lines always reach the core the routing register names. An idle cluster drives no output. Writes to the pending-word range leave every configuration field untouched. The bench's scenarios cover the rest: the exact bit layout of the pending words, fast-path precedence showing up as an absent normal bit, truncation of enable writes to 8 bits, routing field extraction, zero reads from unmapped and unaligned offsets, and the reset state. Random traffic interleaves configuration writes with changing request patterns, and a bench model predicts every pending word.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // local sources per group (timers, mailboxes); fixes the pending-word layout
    localparam int GRP_SRC    = 4;
    // enable register width: normal enables low half, fast enables high half
    localparam int CTL_W      = 2 * GRP_SRC;
    // pending-word bit carrying the shared upstream line
    localparam int UP_BIT     = 2 * GRP_SRC;

    // register offsets
    localparam int OFS_ROUTE  = 'h0C;
    localparam int OFS_TCTL   = 'h40;
    localparam int OFS_MCTL   = 'h50;
    localparam int OFS_ISTAT  = 'h60;
    localparam int OFS_FSTAT  = 'h70;
    localparam int REGION_SZ  = 'h10;

    // routing field positions
    localparam int RT_IRQ_LSB = 0;
    localparam int RT_FIQ_LSB = 2;

endpackage

// File: rtl/irq_src_steer.sv
module irq_src_steer #(
    parameter int SRC_N = 4
) (
    input  logic [SRC_N-1:0]   req,
    input  logic [2*SRC_N-1:0] ctl,
    output logic [SRC_N-1:0]   to_irq,
    output logic [SRC_N-1:0]   to_fiq
);

    // fast enable takes precedence over normal enable for each source
    for (genvar k = 0; k < SRC_N; k++) begin : g_src
        assign to_fiq[k] = req[k] & ctl[SRC_N + k];
        assign to_irq[k] = req[k] & ctl[k] & ~ctl[SRC_N + k];
    end

endmodule

// File: rtl/irq_core_lane.sv
module irq_core_lane
    import irq_router_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [GRP_SRC-1:0] tmr_req,
    input  logic [GRP_SRC-1:0] mb_req,
    input  logic [CTL_W-1:0]   tctl,
    input  logic [CTL_W-1:0]   mctl,
    input  logic               up_irq_hit,
    input  logic               up_fiq_hit,
    output logic [DATA_W-1:0]  irq_word,
    output logic [DATA_W-1:0]  fiq_word,
    output logic               irq_out,
    output logic               fiq_out
);

    logic [GRP_SRC-1:0] tmr_to_irq, tmr_to_fiq;
    logic [GRP_SRC-1:0] mb_to_irq,  mb_to_fiq;

    irq_src_steer #(.SRC_N(GRP_SRC)) u_tmr (
        .req    (tmr_req),
        .ctl    (tctl),
        .to_irq (tmr_to_irq),
        .to_fiq (tmr_to_fiq)
    );

    irq_src_steer #(.SRC_N(GRP_SRC)) u_mb (
        .req    (mb_req),
        .ctl    (mctl),
        .to_irq (mb_to_irq),
        .to_fiq (mb_to_fiq)
    );

    always_comb begin
        irq_word = '0;
        fiq_word = '0;
        irq_word[GRP_SRC-1:0]         = tmr_to_irq;
        fiq_word[GRP_SRC-1:0]         = tmr_to_fiq;
        irq_word[2*GRP_SRC-1:GRP_SRC] = mb_to_irq;
        fiq_word[2*GRP_SRC-1:GRP_SRC] = mb_to_fiq;
        irq_word[UP_BIT]              = up_irq_hit;
        fiq_word[UP_BIT]              = up_fiq_hit;
    end

    assign irq_out = |irq_word;
    assign fiq_out = |fiq_word;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [CORE_W-1:0]                rt_irq,
    output logic [CORE_W-1:0]                rt_fiq,
    output logic [NUM_CORES-1:0][CTL_W-1:0]  tctl,
    output logic [NUM_CORES-1:0][CTL_W-1:0]  mctl
);

    typedef struct packed {
        logic [CORE_W-1:0]               rt_irq;
        logic [CORE_W-1:0]               rt_fiq;
        logic [NUM_CORES-1:0][CTL_W-1:0] tctl;
        logic [NUM_CORES-1:0][CTL_W-1:0] mctl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // upper data bits are dropped by design
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CTL_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_ROUTE)) begin
                cfg_d.rt_irq = wdata[RT_IRQ_LSB +: CORE_W];
                cfg_d.rt_fiq = wdata[RT_FIQ_LSB +: CORE_W];
            end
            for (int c = 0; c < NUM_CORES; c++) begin
                if (addr == ADDR_W'(OFS_TCTL + 4 * c)) begin
                    cfg_d.tctl[c] = wdata[CTL_W-1:0];
                end
                if (addr == ADDR_W'(OFS_MCTL + 4 * c)) begin
                    cfg_d.mctl[c] = wdata[CTL_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rt_irq = cfg_q.rt_irq;
    assign rt_fiq = cfg_q.rt_fiq;
    assign tctl   = cfg_q.tctl;
    assign mctl   = cfg_q.mctl;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = 2
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [CORE_W-1:0]                rt_irq,
    input  logic [CORE_W-1:0]                rt_fiq,
    input  logic [NUM_CORES-1:0][CTL_W-1:0]  tctl,
    input  logic [NUM_CORES-1:0][CTL_W-1:0]  mctl,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] irq_word,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] fiq_word,
    output logic [DATA_W-1:0]                rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_ROUTE)) begin
            rdata[RT_IRQ_LSB +: CORE_W] = rt_irq;
            rdata[RT_FIQ_LSB +: CORE_W] = rt_fiq;
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == ADDR_W'(OFS_TCTL + 4 * c)) begin
                rdata = DATA_W'(tctl[c]);
            end
            if (addr == ADDR_W'(OFS_MCTL + 4 * c)) begin
                rdata = DATA_W'(mctl[c]);
            end
            if (addr == ADDR_W'(OFS_ISTAT + 4 * c)) begin
                rdata = irq_word[c];
            end
            if (addr == ADDR_W'(OFS_FSTAT + 4 * c)) begin
                rdata = fiq_word[c];
            end
        end
    end

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,   // 2..4: routing fields are two bits wide
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CORES*GRP_SRC-1:0]   timer_req,
    input  logic [NUM_CORES*GRP_SRC-1:0]   mbox_pend,
    input  logic                           up_irq,
    input  logic                           up_fiq,
    input  logic                           acc_we,
    input  logic [ADDR_W-1:0]              acc_addr,
    input  logic [DATA_W-1:0]              acc_wdata,
    output logic [DATA_W-1:0]              acc_rdata,
    output logic [NUM_CORES-1:0]           core_irq,
    output logic [NUM_CORES-1:0]           core_fiq
);

    localparam int CORE_W = $clog2(NUM_CORES);

    logic [CORE_W-1:0]                rt_irq, rt_fiq;
    logic [NUM_CORES-1:0][CTL_W-1:0]  tctl, mctl;
    logic [NUM_CORES-1:0][DATA_W-1:0] irq_word, fiq_word;

    irq_cfg_regs #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CORE_W    (CORE_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_we),
        .addr   (acc_addr),
        .wdata  (acc_wdata),
        .rt_irq (rt_irq),
        .rt_fiq (rt_fiq),
        .tctl   (tctl),
        .mctl   (mctl)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic up_irq_hit, up_fiq_hit;
        assign up_irq_hit = up_irq & (rt_irq == CORE_W'(c));
        assign up_fiq_hit = up_fiq & (rt_fiq == CORE_W'(c));

        irq_core_lane #(.DATA_W(DATA_W)) u_lane (
            .tmr_req    (timer_req[c*GRP_SRC +: GRP_SRC]),
            .mb_req     (mbox_pend[c*GRP_SRC +: GRP_SRC]),
            .tctl       (tctl[c]),
            .mctl       (mctl[c]),
            .up_irq_hit (up_irq_hit),
            .up_fiq_hit (up_fiq_hit),
            .irq_word   (irq_word[c]),
            .fiq_word   (fiq_word[c]),
            .irq_out    (core_irq[c]),
            .fiq_out    (core_fiq[c])
        );
    end

    irq_read_mux #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CORE_W    (CORE_W)
    ) u_rd (
        .addr     (acc_addr),
        .rt_irq   (rt_irq),
        .rt_fiq   (rt_fiq),
        .tctl     (tctl),
        .mctl     (mctl),
        .irq_word (irq_word),
        .fiq_word (fiq_word),
        .rdata    (acc_rdata)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CORES*GRP_SRC-1:0]    timer_req,
    input logic [NUM_CORES*GRP_SRC-1:0]    mbox_pend,
    input logic                            up_irq,
    input logic                            up_fiq,
    input logic                            acc_we,
    input logic [ADDR_W-1:0]               acc_addr,
    input logic [DATA_W-1:0]               acc_wdata,
    input logic [NUM_CORES-1:0]            core_irq,
    input logic [NUM_CORES-1:0]            core_fiq,
    input logic [CORE_W-1:0]               rt_irq,
    input logic [CORE_W-1:0]               rt_fiq,
    input logic [NUM_CORES-1:0][CTL_W-1:0] tctl,
    input logic [NUM_CORES-1:0][CTL_W-1:0] mctl
);

    logic stat_wr;
    assign stat_wr = acc_we && (acc_addr >= ADDR_W'(OFS_ISTAT))
                            && (acc_addr <  ADDR_W'(OFS_FSTAT + REGION_SZ));

    // idle cluster drives no output (R4, R9)
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_req == '0 && mbox_pend == '0 && !up_irq && !up_fiq)
            |-> (core_irq == '0 && core_fiq == '0));

    // upstream lines reach the routed core regardless of enables
    p_upirq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_irq |-> core_irq[rt_irq]);
    p_upfiq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_fiq |-> core_fiq[rt_fiq]);

    // pending-word range is read-only
    p_statro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ($stable(tctl) && $stable(mctl)
                     && $stable(rt_irq) && $stable(rt_fiq)));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
        p_ctlwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_we && acc_addr == ADDR_W'(OFS_TCTL + 4 * c))
                |=> tctl[c] == $past(acc_wdata[CTL_W-1:0]));
        for (genvar k = 0; k < GRP_SRC; k++) begin : g_k
            p_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (timer_req[c*GRP_SRC+k] && tctl[c][GRP_SRC+k]) |-> core_fiq[c]);
            p_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (mbox_pend[c*GRP_SRC+k] && mctl[c][k] && !mctl[c][GRP_SRC+k])
                    |-> core_irq[c]);
        end
    end

endmodule

bind core_irq_router irq_router_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CORE_W    (CORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_req (timer_req),
    .mbox_pend (mbox_pend),
    .up_irq    (up_irq),
    .up_fiq    (up_fiq),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .core_irq  (core_irq),
    .core_fiq  (core_fiq),
    .rt_irq    (rt_irq),
    .rt_fiq    (rt_fiq),
    .tctl      (tctl),
    .mctl      (mctl)
);

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_req = '0;
    logic [15:0] mbox_pend = '0;
    logic        up_irq = 1'b0;
    logic        up_fiq = 1'b0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [3:0]  core_irq, core_fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] m_rt_irq, m_rt_fiq;
    logic [7:0] m_tctl [NC];
    logic [7:0] m_mctl [NC];

    always #10 clk = ~clk;

    core_irq_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_req (timer_req),
        .mbox_pend (mbox_pend),
        .up_irq    (up_irq),
        .up_fiq    (up_fiq),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .core_irq  (core_irq),
        .core_fiq  (core_fiq)
    );

    function automatic logic [31:0] exp_word(int c, bit fq);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) begin
            logic ti, tf, mi, mf;
            ti = m_tctl[c][k]; tf = m_tctl[c][4+k];
            mi = m_mctl[c][k]; mf = m_mctl[c][4+k];
            if (fq) begin
                w[k]   = timer_req[c*4+k] && tf;
                w[4+k] = mbox_pend[c*4+k] && mf;
            end else begin
                w[k]   = timer_req[c*4+k] && ti && !tf;
                w[4+k] = mbox_pend[c*4+k] && mi && !mf;
            end
        end
        w[8] = fq ? (up_fiq && m_rt_fiq == 2'(c)) : (up_irq && m_rt_irq == 2'(c));
        return w;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        if (a == 'h0C) return {28'b0, m_rt_fiq, m_rt_irq};
        for (int c = 0; c < NC; c++) begin
            if (a == 'h40 + 4*c) return {24'b0, m_tctl[c]};
            if (a == 'h50 + 4*c) return {24'b0, m_mctl[c]};
            if (a == 'h60 + 4*c) return exp_word(c, 0);
            if (a == 'h70 + 4*c) return exp_word(c, 1);
        end
        return '0;
    endfunction

    task automatic model_write(int a, logic [31:0] d);
        if (a == 'h0C) begin
            m_rt_irq = d[1:0];
            m_rt_fiq = d[3:2];
        end
        for (int c = 0; c < NC; c++) begin
            if (a == 'h40 + 4*c) m_tctl[c] = d[7:0];
            if (a == 'h50 + 4*c) m_mctl[c] = d[7:0];
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        acc_we = 1'b1; acc_addr = 8'(a); acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(string tag, int a);
        acc_addr = 8'(a);
        #1;
        chk(tag, acc_rdata, exp_read(a));
    endtask

    task automatic check_outputs(string tag);
        logic [3:0] ei, ef;
        #1;
        for (int c = 0; c < NC; c++) begin
            ei[c] = |exp_word(c, 0);
            ef[c] = |exp_word(c, 1);
        end
        chk(tag, {28'b0, core_irq}, {28'b0, ei});
        chk(tag, {28'b0, core_fiq}, {28'b0, ef});
    endtask

    task automatic check_cfg(string tag);
        rd_chk(tag, 'h0C);
        for (int c = 0; c < NC; c++) begin
            rd_chk(tag, 'h40 + 4*c);
            rd_chk(tag, 'h50 + 4*c);
        end
    endtask

    task automatic check_status(string tag);
        for (int c = 0; c < NC; c++) begin
            rd_chk(tag, 'h60 + 4*c);
            rd_chk(tag, 'h70 + 4*c);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_rt_irq = '0; m_rt_fiq = '0;
        for (int c = 0; c < NC; c++) begin m_tctl[c] = '0; m_mctl[c] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, all sources masked, upstream to core 0
        check_cfg("R1");
        timer_req = '1; mbox_pend = '1; up_irq = 1'b1; up_fiq = 1'b1;
        #1;
        chk("R1", {28'b0, core_irq}, 32'h1);
        chk("R1", {28'b0, core_fiq}, 32'h1);
        up_irq = 1'b0; up_fiq = 1'b0;
        timer_req = '0; mbox_pend = '0;

        // R2: fast enable wins over normal enable
        wr('h44, 32'h0000_0011);
        timer_req[4] = 1'b1;
        #1;
        chk("R2", core_fiq[1], 1'b1);
        chk("R2", core_irq[1], 1'b0);
        acc_addr = 8'h74; #1; chk("R2", acc_rdata, 32'h1);
        acc_addr = 8'h64; #1; chk("R2", acc_rdata, 32'h0);

        // R3: normal enable alone
        wr('h44, 32'h0000_0001);
        #1;
        chk("R3", core_irq[1], 1'b1);
        chk("R3", core_fiq[1], 1'b0);
        acc_addr = 8'h64; #1; chk("R3", acc_rdata, 32'h1);

        // R4: masked source, and enabled but idle source
        timer_req[5] = 1'b1;
        #1;
        acc_addr = 8'h64; #1; chk("R4", acc_rdata, 32'h1);
        timer_req = '0;
        #1;
        chk("R4", {28'b0, core_irq}, 32'h0);

        // R9: outputs follow a request without a clock edge
        timer_req[4] = 1'b1;
        #1;
        chk("R9", core_irq[1], 1'b1);
        timer_req[4] = 1'b0;
        #1;
        chk("R9", core_irq[1], 1'b0);

        // R6: routing fields, upper bits dropped
        wr('h0C, 32'hFFFF_FFF6);
        acc_addr = 8'h0C; #1; chk("R6", acc_rdata, 32'h6);
        up_irq = 1'b1; up_fiq = 1'b1;
        #1;
        chk("R6", {28'b0, core_irq}, 32'h4);
        chk("R6", {28'b0, core_fiq}, 32'h2);

        // R7: upstream not gated by zero enables
        wr('h48, 32'h0);
        acc_addr = 8'h68; #1; chk("R7", acc_rdata, 32'h100);
        acc_addr = 8'h74; #1; chk("R7", acc_rdata, 32'h100);
        up_irq = 1'b0; up_fiq = 1'b0;

        // R8: enable registers keep low 8 bits
        wr('h54, 32'hDEAD_BEEF);
        acc_addr = 8'h54; #1; chk("R8", acc_rdata, 32'hEF);
        mbox_pend[7:4] = 4'hF;
        #1;
        // R5: mailbox 0 normal (bit 4), mailboxes 1..3 fast (bits 5..7)
        acc_addr = 8'h64; #1; chk("R5", acc_rdata, 32'h10);
        acc_addr = 8'h74; #1; chk("R5", acc_rdata, 32'hE0);
        mbox_pend = '0;

        // R10: read-only, unmapped and unaligned writes ignored
        wr('h60, 32'hFFFF_FFFF);
        wr('h74, 32'hFFFF_FFFF);
        wr('h20, 32'hFFFF_FFFF);
        wr('h41, 32'hFFFF_FFFF);
        wr('h9C, 32'hFFFF_FFFF);
        check_cfg("R10");
        acc_addr = 8'h00; #1; chk("R10", acc_rdata, 32'h0);
        acc_addr = 8'h41; #1; chk("R10", acc_rdata, 32'h0);
        acc_addr = 8'h80; #1; chk("R10", acc_rdata, 32'h0);
        acc_addr = 8'hFC; #1; chk("R10", acc_rdata, 32'h0);

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int a;
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 3)      a = int'($urandom_range(0, 255));
            else if (pick < 4) a = 'h0C;
            else if (pick < 6) a = 'h40 + 4 * int'($urandom_range(0, 3));
            else if (pick < 8) a = 'h50 + 4 * int'($urandom_range(0, 3));
            else               a = 'h60 + 4 * int'($urandom_range(0, 7));
            wr(a, $urandom());
            timer_req = 16'($urandom());
            mbox_pend = 16'($urandom());
            up_irq    = 1'($urandom());
            up_fiq    = 1'($urandom());
            check_outputs("R9");
            check_status("R5");
            if (i % 20 == 0) check_cfg("R8");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule